// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two parallel buses, called side A and side B, and keeps a separate storage element for each direction of travel. Each storage element works in one of three ways, chosen by the two controls of its direction.

- **Pass-through:** the output follows the input in the same cycle.
- **Hold:** the output keeps the last stored word, however the input moves.
- **Capture:** a rising transition on the direction's strobe loads the input word.

Each side has an output-enable that tells the pad ring whether to drive the side or leave it at high impedance. The enable for side B is active high and the enable for side A is active low. Each side is presented as a data input, a data output and a drive flag, and the pad ring maps these to bidirectional pins.

All registers run on one core clock. Each strobe is a plain signal that passes through a small synchronizer. A rising transition on it is recognised by comparing two successive samples. While a direction's pass control is high, its storage element reloads on every core clock edge. When the pass control drops, the element therefore keeps the word from the last edge. A low-active reset clears both storage elements asynchronously and is released in step with the clock.

Top module: `bus_xcvr`

## Requirements
- R1: With `ab_pass` high, `b_out` equals `a_in` in the same cycle, with no clock edge needed, for every bit of the WIDTH-bit word (WIDTH defaults to 18).
- R2: While `ab_pass` is high, the A-to-B storage element reloads on every core clock edge. After `ab_pass` falls, `b_out` shows the `a_in` word present at the last edge with `ab_pass` high.
- R3: With `ab_pass` low and `ab_strobe` held at a steady level, either low or high, `b_out` does not change when `a_in` changes.
- R4: With `ab_pass` low, a low-to-high change of `ab_strobe` loads `a_in` into the A-to-B storage element on core clock edge number SYNC_STAGES+1 after the change (SYNC_STAGES defaults to 2). `b_out` keeps its old value until that edge.
- R5: A high-to-low change of `ab_strobe` loads nothing, so `b_out` keeps its value.
- R6: `b_oe` is high exactly when `ab_drive` is high; the side-B drive enable is active high.
- R7: `a_oe` is high exactly when `ba_drive_n` is low; the side-A drive enable is active low.
- R8: The B-to-A direction shows the behaviour of R1 to R5, using `ba_pass`, `ba_strobe`, `b_in` and `a_out`.
- R9: While `rst_n` is low, both storage elements read zero, and with the pass controls low both data outputs read zero at once.
- R10: The A-to-B controls and data have no effect on `a_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous low-active reset, released on the clock |
| a_in | input | WIDTH | Word received on side A |
| a_out | output | WIDTH | Word to drive onto side A (B-to-A path) |
| a_oe | output | 1 | Drive side A when high |
| b_in | input | WIDTH | Word received on side B |
| b_out | output | WIDTH | Word to drive onto side B (A-to-B path) |
| b_oe | output | 1 | Drive side B when high |
| ab_pass | input | 1 | A-to-B pass-through control |
| ab_strobe | input | 1 | A-to-B capture strobe, acting on its rising transition |
| ab_drive | input | 1 | Side-B output enable, active high |
| ba_pass | input | 1 | B-to-A pass-through control |
| ba_strobe | input | 1 | B-to-A capture strobe, acting on its rising transition |
| ba_drive_n | input | 1 | Side-A output enable, active low |

## Verification
Pass-through, both drive enables and the asynchronous clear act within the same cycle, so the bench checks them one nanosecond after it changes the inputs, before any clock edge. A strobe capture lands on edge SYNC_STAGES+1 after the strobe rises. The bench therefore checks that the old word is still present after SYNC_STAGES edges and that the new word is present after one more. Hold checks and falling-strobe checks wait at least six edges, well past any capture window, before the bench looks at the output again. The bench drives inputs and samples outputs on the falling clock edge.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  typedef enum logic [1:0] {
    STORE_HOLD    = 2'd0,
    STORE_FOLLOW  = 2'd1,
    STORE_CAPTURE = 2'd2
  } store_op_e;

  // Pass-through has priority over a strobe edge.
  function automatic store_op_e pick_op(input logic pass, input logic rise);
    if (pass)      return STORE_FOLLOW;
    else if (rise) return STORE_CAPTURE;
    else           return STORE_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = strobe;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], strobe};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = 18,
  parameter int unsigned STAGES = 2,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  input  logic             pass,
  input  logic             strobe,
  input  logic             drive,
  output logic [WIDTH-1:0] d_out,
  output logic             oe
);
  logic             rise;
  store_op_e        op;
  logic             load_en;
  logic [WIDTH-1:0] store_d;
  logic [WIDTH-1:0] store_q;

  xcvr_edge_det #(.STAGES(STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .rise   (rise)
  );

  always_comb begin
    op      = pick_op(pass, rise);
    load_en = 1'b0;
    store_d = store_q;
    case (op)
      STORE_FOLLOW, STORE_CAPTURE: begin
        load_en = 1'b1;
        store_d = d_in;
      end
      default: begin
        load_en = 1'b0;
        store_d = store_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       store_q <= '0;
    else if (load_en) store_q <= store_d;
  end

  assign d_out = pass ? d_in : store_q;

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe = ~drive;
    end else begin : g_oe_high
      assign oe = drive;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_pass,
  input  logic             ab_strobe,
  input  logic             ab_drive,
  input  logic             ba_pass,
  input  logic             ba_strobe,
  input  logic             ba_drive_n
);
  logic core_rst_n;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  xcvr_lane #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .OE_LOW(1'b0)) u_a2b (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .d_in   (a_in),
    .pass   (ab_pass),
    .strobe (ab_strobe),
    .drive  (ab_drive),
    .d_out  (b_out),
    .oe     (b_oe)
  );

  xcvr_lane #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .OE_LOW(1'b1)) u_b2a (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .d_in   (b_in),
    .pass   (ba_pass),
    .strobe (ba_strobe),
    .drive  (ba_drive_n),
    .d_out  (a_out),
    .oe     (a_oe)
  );
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             ab_pass,
  input logic             ab_strobe,
  input logic             ab_drive,
  input logic             ba_pass,
  input logic             ba_strobe,
  input logic             ba_drive_n
);
  localparam int unsigned QUIET = SYNC_STAGES + RST_STAGES + 3;
  localparam int unsigned CW    = $clog2(QUIET + 1) + 1;

  logic          ab_last, ba_last;
  logic [CW-1:0] ab_quiet, ba_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_last  <= 1'b0;
      ba_last  <= 1'b0;
      ab_quiet <= '0;
      ba_quiet <= '0;
    end else begin
      ab_last <= ab_strobe;
      ba_last <= ba_strobe;
      if (ab_strobe != ab_last)          ab_quiet <= '0;
      else if (ab_quiet < CW'(QUIET))    ab_quiet <= ab_quiet + 1'b1;
      if (ba_strobe != ba_last)          ba_quiet <= '0;
      else if (ba_quiet < CW'(QUIET))    ba_quiet <= ba_quiet + 1'b1;
    end
  end

  a_r1_ab_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass |-> (b_out == a_in));
  a_r8_ba_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass |-> (a_out == b_in));
  a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && $past(!ab_pass) && ab_quiet >= CW'(QUIET)) |-> $stable(b_out));
  a_r8_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && $past(!ba_pass) && ba_quiet >= CW'(QUIET)) |-> $stable(a_out));
  a_r6_b_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_drive |-> !b_oe);
  a_r7_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ba_drive_n |-> !a_oe);
endmodule

bind bus_xcvr bus_xcvr_chk #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .RST_STAGES(RST_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_pass(ab_pass),
  .ab_strobe(ab_strobe), .ab_drive(ab_drive), .ba_pass(ba_pass),
  .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
);

// File: tb/bus_xcvr_test.sv
module bus_xcvr_test;
  localparam int W  = 18;
  localparam int SS = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_pass, ab_strobe, ab_drive, ba_pass, ba_strobe, ba_drive_n;
  int           total = 0;
  int           bad   = 0;
  bit           done  = 1'b0;

  always #4 clk = ~clk;

  bus_xcvr #(.WIDTH(W), .SYNC_STAGES(SS), .RST_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_pass(ab_pass),
    .ab_strobe(ab_strobe), .ab_drive(ab_drive), .ba_pass(ba_pass),
    .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // dir 0: A to B, dir 1: B to A
  task automatic set_in(input bit dir, input logic [W-1:0] v);
    if (dir) b_in = v; else a_in = v;
  endtask
  task automatic set_pass(input bit dir, input logic v);
    if (dir) ba_pass = v; else ab_pass = v;
  endtask
  task automatic set_strobe(input bit dir, input logic v);
    if (dir) ba_strobe = v; else ab_strobe = v;
  endtask
  function automatic logic [W-1:0] get_out(input bit dir);
    return dir ? a_out : b_out;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    edges(2);
    check("R9 b_out in reset", b_out, '0);
    check("R9 a_out in reset", a_out, '0);
    check("R6 b_oe off", {{(W-1){1'b0}}, b_oe}, '0);
    check("R7 a_oe off", {{(W-1){1'b0}}, a_oe}, '0);
    rst_n = 1'b1;
    edges(4);
  endtask

  task automatic t_pass(input bit dir, input string tag);
    set_pass(dir, 1'b1);
    set_in(dir, 18'h2A5C3);
    #1 check({tag, " pass same cycle"}, get_out(dir), 18'h2A5C3);
    set_in(dir, 18'h15A3C);
    #1 check({tag, " pass follows"}, get_out(dir), 18'h15A3C);
    edges(1);
  endtask

  task automatic t_follow(input bit dir, input string tag);
    set_in(dir, 18'h0BEEF);
    edges(1);
    set_pass(dir, 1'b0);
    set_in(dir, 18'h3FFFF);
    #1 check({tag, " keeps last loaded"}, get_out(dir), 18'h0BEEF);
  endtask

  task automatic t_hold_capture(input bit dir, input string tag);
    edges(1);
    set_in(dir, 18'h12345);
    edges(6);
    check({tag, " hold strobe low"}, get_out(dir), 18'h0BEEF);
    set_in(dir, 18'h2C0DE);
    set_strobe(dir, 1'b1);
    edges(SS);
    check({tag, " no load before edge SS+1"}, get_out(dir), 18'h0BEEF);
    edges(1);
    check({tag, " capture on rise"}, get_out(dir), 18'h2C0DE);
    set_in(dir, 18'h00F0F);
    edges(6);
    check({tag, " hold strobe high"}, get_out(dir), 18'h2C0DE);
    set_strobe(dir, 1'b0);
    edges(6);
    check({tag, " no load on fall"}, get_out(dir), 18'h2C0DE);
  endtask

  task automatic t_drive;
    ab_drive = 1'b1;
    #1 check("R6 b_oe on", {{(W-1){1'b0}}, b_oe}, 18'd1);
    ab_drive = 1'b0;
    #1 check("R6 b_oe off again", {{(W-1){1'b0}}, b_oe}, 18'd0);
    ba_drive_n = 1'b0;
    #1 check("R7 a_oe on when low", {{(W-1){1'b0}}, a_oe}, 18'd1);
    ba_drive_n = 1'b1;
    #1 check("R7 a_oe off when high", {{(W-1){1'b0}}, a_oe}, 18'd0);
    edges(1);
  endtask

  task automatic t_mid_reset;
    rst_n = 1'b0;
    #1;
    check("R9 async clear b_out", b_out, '0);
    check("R9 async clear a_out", a_out, '0);
    edges(1);
    rst_n = 1'b1;
    edges(4);
  endtask

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_pass = 1'b0; ab_strobe = 1'b0; ab_drive = 1'b0;
    ba_pass = 1'b0; ba_strobe = 1'b0; ba_drive_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_drive;
    t_pass(1'b0, "R1");
    t_follow(1'b0, "R2");
    t_hold_capture(1'b0, "R3/R4/R5 A-to-B");
    check("R10 a_out untouched", a_out, '0);
    t_pass(1'b1, "R8 B-to-A");
    t_follow(1'b1, "R8 B-to-A");
    t_hold_capture(1'b1, "R8 B-to-A");
    check("R10 b_out still held", b_out, 18'h2C0DE);
    t_mid_reset;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule